// File: doc/BRIEF.md
# Two-Stage Lockable Watchdog Timer

This peripheral supervises software through a down-counter on a small APB-style register bus. Counting advances only on clock cycles where the `tick` input is high and the run bit of the control register is set. When the counter passes zero for the first time, it raises an interrupt flag and reloads from the load register.

If the flag is still set when the counter passes zero again, and resets are enabled, the block drives a system reset that stays asserted until the bus reset. Software services the timer by writing anything to the clear register. That write drops the flag and restarts the count from the load value.

A key register guards every other writable register against stray writes. The block accepts writes to them only while it is unlocked. It is unlocked after reset.

Top module: `wdog_twostage`

## Requirements
- R1: After `rst_n` is low, load and counter read 0xFFFFFFFF, control reads 0, the flag is clear, the block is unlocked (lock read 0), and `irq` and `sys_rst` are low.
- R2: The counter falls by one on each clock edge where `tick` is 1, control bit 0 (run) is 1 and no bus write reloads it. With run at 0 the value holds.
- R3: On a counting edge with the counter at 0 and the flag clear, the flag sets and the counter takes the load value, so one stage lasts load+1 ticks.
- R4: On a counting edge with the counter at 0 and the flag already set, the counter reloads. If control bit 1 (reset enable) is 1, `sys_rst` rises on that edge and stays high until `rst_n`. With bit 1 at 0 no reset is raised.
- R5: An accepted write of any data to offset 0x00C clears the flag and reloads the counter from the load register. If an expiry falls on the same edge, the clear wins and no reset follows.
- R6: An accepted write to offset 0x000 sets the load register and the counter to the written value on that edge. It suppresses counting on that edge.
- R7: Offset 0x010 bit 0 reads the flag. Offset 0x014 bit 0 reads the flag AND run. `irq` equals the 0x014 bit.
- R8: Writing 0x1ACCE551 to offset 0xC00 unlocks the block. Writing any other value there locks it. Reading 0xC00 returns 1 when locked and 0 when unlocked.
- R9: While locked, writes to the load, control and clear offsets change nothing.
- R10: Offset 0x004 reads the counter and ignores writes. Offset 0x008 reads control in bits 1:0. Offset 0x00C and unmapped offsets read 0.
- R11: A write takes effect only in the access phase, where `psel`, `penable` and `pwrite` are all 1. Reads return `prdata` combinationally from `paddr` with no wait state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low bus reset |
| psel | input | 1 | Peripheral select |
| penable | input | 1 | Access phase marker |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 12 | Byte offset |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data |
| tick | input | 1 | Count enable pulse |
| irq | output | 1 | Masked first-stage interrupt |
| sys_rst | output | 1 | Sticky second-stage reset request |

## Verification
A bus reload and a counter expiry can land on the same clock edge. The sharpest case is a clear write whose access phase carries a tick while the counter sits at zero with the flag set. The bench steers into that state by counting down with a small load. It then issues the clear with `tick` held high only in the access phase, and expects the flag to be clear, the counter to hold the load value and `sys_rst` to stay low. Random traffic keeps producing load, clear and control writes on ticking cycles, and a bench model that applies bus-before-count priority judges every one of them.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

   localparam int CTRL_W = 2;

   localparam logic [11:0] OFS_LOAD  = 12'h000;
   localparam logic [11:0] OFS_VALUE = 12'h004;
   localparam logic [11:0] OFS_CTRL  = 12'h008;
   localparam logic [11:0] OFS_ICLR  = 12'h00C;
   localparam logic [11:0] OFS_RIS   = 12'h010;
   localparam logic [11:0] OFS_MIS   = 12'h014;
   localparam logic [11:0] OFS_LOCK  = 12'hC00;

   typedef enum logic [2:0] {
      SEL_LOAD,
      SEL_VALUE,
      SEL_CTRL,
      SEL_ICLR,
      SEL_RIS,
      SEL_MIS,
      SEL_LOCK,
      SEL_NONE
   } wdog_sel_e;

   function automatic wdog_sel_e wdog_decode(input logic [11:0] ofs, input logic hi_zero);
      wdog_sel_e s;
      s = SEL_NONE;
      if (hi_zero) begin
         case (ofs)
            OFS_LOAD:  s = SEL_LOAD;
            OFS_VALUE: s = SEL_VALUE;
            OFS_CTRL:  s = SEL_CTRL;
            OFS_ICLR:  s = SEL_ICLR;
            OFS_RIS:   s = SEL_RIS;
            OFS_MIS:   s = SEL_MIS;
            OFS_LOCK:  s = SEL_LOCK;
            default:   s = SEL_NONE;
         endcase
      end
      return s;
   endfunction

endpackage

// File: rtl/wdog_bus.sv
module wdog_bus
   import wdog_pkg::*;
#(
   parameter int                DATA_W     = 32,
   parameter int                ADDR_W     = 12,
   parameter logic [DATA_W-1:0] UNLOCK_KEY = DATA_W'(32'h1ACCE551)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              psel,
   input  logic              penable,
   input  logic              pwrite,
   input  logic [ADDR_W-1:0] paddr,
   input  logic [DATA_W-1:0] pwdata,
   output wdog_sel_e         sel,
   output logic              wr_any,
   output logic              locked,
   output logic              load_we,
   output logic              ctrl_we,
   output logic              clr_we
);

   logic hi_zero;
   logic open_wr;

   generate
      if (ADDR_W > 12) begin : g_wide_addr
         assign hi_zero = ~|paddr[ADDR_W-1:12];
      end else begin : g_exact_addr
         assign hi_zero = 1'b1;
      end
   endgenerate

   assign sel     = wdog_decode(paddr[11:0], hi_zero);
   assign wr_any  = psel & penable & pwrite;
   assign open_wr = wr_any & ~locked;

   assign load_we = open_wr & (sel == SEL_LOAD);
   assign ctrl_we = open_wr & (sel == SEL_CTRL);
   assign clr_we  = open_wr & (sel == SEL_ICLR);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         locked <= 1'b0;
      end else if (wr_any && sel == SEL_LOCK) begin
         locked <= (pwdata != UNLOCK_KEY);
      end
   end

endmodule

// File: rtl/wdog_cfg.sv
module wdog_cfg
   import wdog_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int CNT_W  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_we,
   input  logic              ctrl_we,
   input  logic [DATA_W-1:0] wdata,
   output logic [CNT_W-1:0]  load_q,
   output logic [CTRL_W-1:0] ctrl_q
);

   localparam logic [CNT_W-1:0] LOAD_INIT = '1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         load_q <= LOAD_INIT;
      end else if (load_we) begin
         load_q <= wdata[CNT_W-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
      end else if (ctrl_we) begin
         ctrl_q <= wdata[CTRL_W-1:0];
      end
   end

endmodule

// File: rtl/wdog_core.sv
module wdog_core #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             cnt_en,
   input  logic             rst_en,
   input  logic             load_we,
   input  logic             clr_we,
   input  logic [CNT_W-1:0] load_wdata,
   input  logic [CNT_W-1:0] load_q,
   output logic [CNT_W-1:0] cnt_q,
   output logic             flag_q,
   output logic             sys_rst_q,
   output logic             irq
);

   localparam logic [CNT_W-1:0] CNT_INIT = '1;
   localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

   logic bus_reload;
   logic step;
   logic at_zero;
   logic expire;

   assign bus_reload = load_we | clr_we;
   assign step       = cnt_en & tick & ~bus_reload;
   assign at_zero    = (cnt_q == '0);
   assign expire     = step & at_zero;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= CNT_INIT;
      end else if (load_we) begin
         cnt_q <= load_wdata;
      end else if (clr_we) begin
         cnt_q <= load_q;
      end else if (step) begin
         cnt_q <= at_zero ? load_q : (cnt_q - CNT_ONE);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
      end else if (clr_we) begin
         flag_q <= 1'b0;
      end else if (expire) begin
         flag_q <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sys_rst_q <= 1'b0;
      end else if (expire && flag_q && rst_en) begin
         sys_rst_q <= 1'b1;
      end
   end

   assign irq = flag_q & cnt_en;

endmodule

// File: rtl/wdog_twostage.sv
module wdog_twostage
   import wdog_pkg::*;
#(
   parameter int                DATA_W     = 32,
   parameter int                ADDR_W     = 12,
   parameter int                CNT_W      = 32,
   parameter logic [DATA_W-1:0] UNLOCK_KEY = DATA_W'(32'h1ACCE551)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              psel,
   input  logic              penable,
   input  logic              pwrite,
   input  logic [ADDR_W-1:0] paddr,
   input  logic [DATA_W-1:0] pwdata,
   output logic [DATA_W-1:0] prdata,
   input  logic              tick,
   output logic              irq,
   output logic              sys_rst
);

   generate
      if (ADDR_W < 12) begin : g_chk_addr
         $error("wdog_twostage: ADDR_W must cover offset 0xC00");
      end
      if (CNT_W < 2 || CNT_W > DATA_W) begin : g_chk_cnt
         $error("wdog_twostage: CNT_W must lie in 2..DATA_W");
      end
      if (DATA_W < CTRL_W) begin : g_chk_data
         $error("wdog_twostage: DATA_W too narrow for control");
      end
   endgenerate

   wdog_sel_e          sel;
   logic               wr_any;
   logic               locked;
   logic               load_we;
   logic               ctrl_we;
   logic               clr_we;
   logic [CNT_W-1:0]   load_q;
   logic [CTRL_W-1:0]  ctrl_q;
   logic [CNT_W-1:0]   cnt_q;
   logic               flag_q;
   logic               sys_rst_q;
   logic               irq_w;
   logic [DATA_W-1:0]  cnt_ext;
   logic [DATA_W-1:0]  load_ext;

   wdog_bus #(
      .DATA_W     (DATA_W),
      .ADDR_W     (ADDR_W),
      .UNLOCK_KEY (UNLOCK_KEY)
   ) u_bus (
      .clk     (clk),
      .rst_n   (rst_n),
      .psel    (psel),
      .penable (penable),
      .pwrite  (pwrite),
      .paddr   (paddr),
      .pwdata  (pwdata),
      .sel     (sel),
      .wr_any  (wr_any),
      .locked  (locked),
      .load_we (load_we),
      .ctrl_we (ctrl_we),
      .clr_we  (clr_we)
   );

   wdog_cfg #(
      .DATA_W (DATA_W),
      .CNT_W  (CNT_W)
   ) u_cfg (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_we (load_we),
      .ctrl_we (ctrl_we),
      .wdata   (pwdata),
      .load_q  (load_q),
      .ctrl_q  (ctrl_q)
   );

   wdog_core #(
      .CNT_W (CNT_W)
   ) u_core (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick       (tick),
      .cnt_en     (ctrl_q[0]),
      .rst_en     (ctrl_q[1]),
      .load_we    (load_we),
      .clr_we     (clr_we),
      .load_wdata (pwdata[CNT_W-1:0]),
      .load_q     (load_q),
      .cnt_q      (cnt_q),
      .flag_q     (flag_q),
      .sys_rst_q  (sys_rst_q),
      .irq        (irq_w)
   );

   generate
      if (CNT_W == DATA_W) begin : g_full_cnt
         assign cnt_ext  = cnt_q;
         assign load_ext = load_q;
      end else begin : g_pad_cnt
         assign cnt_ext  = {{(DATA_W-CNT_W){1'b0}}, cnt_q};
         assign load_ext = {{(DATA_W-CNT_W){1'b0}}, load_q};
      end
   endgenerate

   always_comb begin
      prdata = '0;
      case (sel)
         SEL_LOAD:  prdata = load_ext;
         SEL_VALUE: prdata = cnt_ext;
         SEL_CTRL:  prdata[CTRL_W-1:0] = ctrl_q;
         SEL_RIS:   prdata[0] = flag_q;
         SEL_MIS:   prdata[0] = irq_w;
         SEL_LOCK:  prdata[0] = locked;
         default:   prdata = '0;
      endcase
   end

   assign irq     = irq_w;
   assign sys_rst = sys_rst_q;

endmodule

// File: rtl/wdog_twostage_chk.sv
module wdog_twostage_chk
   import wdog_pkg::*;
#(
   parameter int CNT_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tick,
   input logic              wr_any,
   input wdog_sel_e         sel,
   input logic              locked,
   input logic              load_we,
   input logic              clr_we,
   input logic [CTRL_W-1:0] ctrl,
   input logic [CNT_W-1:0]  load,
   input logic [CNT_W-1:0]  cnt,
   input logic              flag,
   input logic              irq,
   input logic              sys_rst
);

   logic counting;
   assign counting = ctrl[0] & tick & ~load_we & ~clr_we;

   AST_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
      counting && cnt != '0 |=> cnt == $past(cnt) - CNT_W'(1)); // R2
   AST_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl[0] && !load_we && !clr_we |=> $stable(cnt)); // R2
   AST_FIRST_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
      counting && cnt == '0 && !flag |=> flag && cnt == $past(load)); // R3
   AST_RST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      sys_rst |=> sys_rst); // R4
   AST_RST_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sys_rst) |-> $past(flag) && $past(ctrl[1])); // R4
   AST_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      clr_we |=> !flag && cnt == $past(load)); // R5
   AST_IRQ_MASK: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl[0] |-> !irq); // R7
   AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      locked && wr_any && sel != SEL_LOCK |=> $stable(ctrl) && $stable(load)); // R9

endmodule

bind wdog_twostage wdog_twostage_chk #(.CNT_W(CNT_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .tick    (tick),
   .wr_any  (wr_any),
   .sel     (sel),
   .locked  (locked),
   .load_we (load_we),
   .clr_we  (clr_we),
   .ctrl    (ctrl_q),
   .load    (load_q),
   .cnt     (cnt_q),
   .flag    (flag_q),
   .irq     (irq),
   .sys_rst (sys_rst)
);

// File: tb/tb_wdog_twostage.sv
`timescale 1ns/1ps
module tb_wdog_twostage;
   import wdog_pkg::*;

   localparam logic [31:0] KEY = 32'h1ACCE551;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0, tick = 1'b0;
   logic [11:0] paddr = '0;
   logic [31:0] pwdata = '0;
   logic [31:0] prdata;
   logic        irq, sys_rst;

   int checks = 0;
   int errors = 0;

   logic [31:0] m_load, m_cnt;
   logic [1:0]  m_ctrl;
   logic        m_flag, m_rst, m_lock;

   always #10 clk = ~clk;

   wdog_twostage dut (
      .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
      .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .tick(tick),
      .irq(irq), .sys_rst(sys_rst)
   );

   task automatic model_reset();
      m_load = 32'hFFFF_FFFF; m_cnt = 32'hFFFF_FFFF; m_ctrl = 2'b00;
      m_flag = 1'b0; m_rst = 1'b0; m_lock = 1'b0;
   endtask

   // bus service first, then counting with the control value held before the edge
   task automatic model_step(input logic wr, input logic [11:0] a, input logic [31:0] d, input logic t);
      logic [1:0]  c_old = m_ctrl;
      logic [31:0] l_old = m_load;
      logic        reload = 1'b0;
      if (wr && a == OFS_LOCK) m_lock = (d != KEY);
      else if (wr && !m_lock) begin
         if (a == OFS_LOAD) begin m_load = d; m_cnt = d; reload = 1'b1; end
         else if (a == OFS_CTRL) m_ctrl = d[1:0];
         else if (a == OFS_ICLR) begin m_flag = 1'b0; m_cnt = l_old; reload = 1'b1; end
      end
      if (!reload && t && c_old[0]) begin
         if (m_cnt == 32'd0) begin
            if (m_flag && c_old[1]) m_rst = 1'b1;
            m_flag = 1'b1;
            m_cnt  = l_old;
         end else m_cnt = m_cnt - 32'd1;
      end
   endtask

   task automatic step(input logic s, input logic e, input logic w, input logic [11:0] a,
                       input logic [31:0] d, input logic t);
      psel = s; penable = e; pwrite = w; paddr = a; pwdata = d; tick = t;
      model_step(s & e & w, a, d, t);
      @(negedge clk);
      psel = 1'b0; penable = 1'b0; pwrite = 1'b0; tick = 1'b0;
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic t0, input logic t1);
      step(1'b1, 1'b0, 1'b1, a, d, t0);
      step(1'b1, 1'b1, 1'b1, a, d, t1);
   endtask

   task automatic idle(input int n, input logic t);
      for (int i = 0; i < n; i++) step(1'b0, 1'b0, 1'b0, 12'h000, 32'h0, t);
   endtask

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, got, exp);
      end
   endtask

   task automatic rd(input logic [11:0] a, output logic [31:0] v);
      psel = 1'b1; pwrite = 1'b0; penable = 1'b0; paddr = a;
      #1;
      v = prdata;
   endtask

   task automatic check_all(input string tag);
      logic [31:0] v;
      rd(OFS_LOAD, v);  chk({tag, " R6 load"}, v, m_load);
      rd(OFS_VALUE, v); chk({tag, " R2 value"}, v, m_cnt);
      rd(OFS_CTRL, v);  chk({tag, " R10 ctrl"}, v, {30'd0, m_ctrl});
      rd(OFS_RIS, v);   chk({tag, " R7 raw"}, v, {31'd0, m_flag});
      rd(OFS_MIS, v);   chk({tag, " R7 masked"}, v, {31'd0, m_flag & m_ctrl[0]});
      rd(OFS_LOCK, v);  chk({tag, " R8 lock"}, v, {31'd0, m_lock});
      chk({tag, " R7 irq"}, {31'd0, irq}, {31'd0, m_flag & m_ctrl[0]});
      chk({tag, " R4 sys_rst"}, {31'd0, sys_rst}, {31'd0, m_rst});
      psel = 1'b0; paddr = '0;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      model_reset();
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      #2_000_000;
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic [31:0] v;
      void'($urandom(32'd20240611));
      do_reset();

      // R1 reset state
      check_all("R1");
      rd(OFS_VALUE, v); chk("R1 value after reset", v, 32'hFFFF_FFFF);
      psel = 1'b0;

      // R3 first stage length, then R4 second stage raises sticky reset
      wr(OFS_LOAD, 32'd5, 1'b0, 1'b0);
      wr(OFS_CTRL, 32'd1, 1'b0, 1'b0);
      idle(5, 1'b1);
      rd(OFS_VALUE, v); chk("R3 counter at zero", v, 32'd0);
      rd(OFS_RIS, v);   chk("R3 flag still clear", v, 32'd0);
      idle(1, 1'b1);
      rd(OFS_RIS, v);   chk("R3 flag set on expiry", v, 32'd1);
      rd(OFS_VALUE, v); chk("R3 reload", v, 32'd5);
      chk("R7 irq on expiry", {31'd0, irq}, 32'd1);
      psel = 1'b0;
      wr(OFS_CTRL, 32'd3, 1'b0, 1'b0);
      idle(5, 1'b1);
      chk("R4 no reset before second expiry", {31'd0, sys_rst}, 32'd0);
      idle(1, 1'b1);
      chk("R4 reset on second expiry", {31'd0, sys_rst}, 32'd1);
      wr(OFS_CTRL, 32'd0, 1'b0, 1'b0);
      idle(4, 1'b1);
      chk("R4 reset sticky", {31'd0, sys_rst}, 32'd1);
      rd(OFS_MIS, v); chk("R7 masked off with run clear", v, 32'd0);
      rd(OFS_RIS, v); chk("R7 raw stays with run clear", v, 32'd1);
      psel = 1'b0;
      check_all("R4");

      // R5 clear on the same edge as the second expiry
      do_reset();
      wr(OFS_LOAD, 32'd2, 1'b0, 1'b0);
      wr(OFS_CTRL, 32'd3, 1'b0, 1'b0);
      for (int i = 0; i < 20 && !(m_flag && m_cnt == 32'd0); i++) idle(1, 1'b1);
      chk("R5 setup reached", {31'd0, m_flag}, 32'd1);
      wr(OFS_ICLR, 32'hDEAD_BEEF, 1'b0, 1'b1);
      chk("R5 clear wins over expiry", {31'd0, sys_rst}, 32'd0);
      rd(OFS_RIS, v);   chk("R5 flag cleared", v, 32'd0);
      rd(OFS_VALUE, v); chk("R5 counter reloaded", v, 32'd2);
      psel = 1'b0;

      // R4 reset enable clear: no reset
      do_reset();
      wr(OFS_LOAD, 32'd1, 1'b0, 1'b0);
      wr(OFS_CTRL, 32'd1, 1'b0, 1'b0);
      idle(10, 1'b1);
      chk("R4 no reset with bit1 clear", {31'd0, sys_rst}, 32'd0);
      check_all("R4b");

      // R8 / R9 lock
      wr(OFS_LOCK, 32'd1, 1'b0, 1'b0);
      rd(OFS_LOCK, v); chk("R8 locked reads 1", v, 32'd1);
      psel = 1'b0;
      wr(OFS_LOAD, 32'd7, 1'b0, 1'b0);
      rd(OFS_LOAD, v); chk("R9 load write ignored", v, 32'd1);
      psel = 1'b0;
      wr(OFS_CTRL, 32'd0, 1'b0, 1'b0);
      rd(OFS_CTRL, v); chk("R9 ctrl write ignored", v, 32'd1);
      psel = 1'b0;
      wr(OFS_ICLR, 32'd0, 1'b0, 1'b0);
      rd(OFS_RIS, v); chk("R9 clear ignored", v, 32'd1);
      psel = 1'b0;
      wr(OFS_LOCK, KEY, 1'b0, 1'b0);
      rd(OFS_LOCK, v); chk("R8 key unlocks", v, 32'd0);
      psel = 1'b0;
      wr(OFS_LOCK, KEY ^ 32'd1, 1'b0, 1'b0);
      rd(OFS_LOCK, v); chk("R8 near key locks", v, 32'd1);
      psel = 1'b0;
      wr(OFS_LOCK, KEY, 1'b0, 1'b0);

      // R2 freeze, R6 load write on a tick
      wr(OFS_CTRL, 32'd0, 1'b0, 1'b0);
      wr(OFS_LOAD, 32'd9, 1'b0, 1'b0);
      idle(5, 1'b1);
      rd(OFS_VALUE, v); chk("R2 frozen with run clear", v, 32'd9);
      psel = 1'b0;
      wr(OFS_CTRL, 32'd1, 1'b0, 1'b0);
      idle(3, 1'b1);
      rd(OFS_VALUE, v); chk("R2 three decrements", v, 32'd6);
      psel = 1'b0;
      wr(OFS_LOAD, 32'd40, 1'b0, 1'b1);
      rd(OFS_VALUE, v); chk("R6 load on tick edge", v, 32'd40);
      psel = 1'b0;

      // R10 map, R11 setup phase alone does nothing
      rd(12'h020, v);   chk("R10 unmapped reads 0", v, 32'd0);
      rd(OFS_ICLR, v);  chk("R10 clear reads 0", v, 32'd0);
      psel = 1'b0;
      wr(OFS_VALUE, 32'd3, 1'b0, 1'b0);
      rd(OFS_VALUE, v); chk("R10 value write ignored", v, 32'd40);
      psel = 1'b0;
      step(1'b1, 1'b0, 1'b1, OFS_LOAD, 32'd77, 1'b0);
      rd(OFS_LOAD, v);  chk("R11 setup phase no commit", v, 32'd40);
      psel = 1'b0;

      // constrained random traffic
      for (int i = 0; i < 3000; i++) begin
         int unsigned op = $urandom % 16;
         logic t = ($urandom % 4) != 0;
         if (i % 600 == 599) do_reset();
         case (op)
            9:  wr(OFS_LOAD, (($urandom % 8) == 0) ? $urandom : 32'(1 + $urandom % 12), 1'b0, t);
            10, 14: wr(OFS_ICLR, $urandom, t, t);
            11: wr(OFS_CTRL, $urandom, 1'b0, t);
            12: wr(OFS_LOCK, (($urandom % 3) != 0) ? KEY : 32'd1, t, t);
            13: wr(OFS_VALUE, $urandom, t, t);
            15: step(1'b1, 1'b0, 1'b1, OFS_LOAD, $urandom, t);
            default: idle(1, t);
         endcase
         check_all("RND");
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule